// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the reduced-power states of a small 8-bit microcontroller. Software writes a power control register over a plain register bus. Two bits in that register request a light sleep or a deep sleep. A second register holds one option bit that keeps the converter clocked during the light sleep. From these bits and from three control inputs, the block drives:

- a clock enable for each peripheral,
- a reset hold for each peripheral,
- a force-high request for the two pulse-width outputs,
- an oscillator-stop request.

The light sleep (idle) treats the peripherals in four different ways:

- The core is only halted.
- The capture timer is halted and held in reset.
- Both PWM channels are halted and held in reset, and their pins are forced high.
- The converter is halted unless the option bit is set.

The remaining timers, the serial ports and the external interrupt logic keep their clocks. The deep sleep (power-down) stops the oscillator and therefore every clock. Software can enter power-down only while the external permission input is high.

The block has no data stream. All of its pins are plain control and status signals, so there is no back-pressure to manage. Register writes complete in a single cycle and are never stalled. Both registers are read back combinationally.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset both registers read zero, every bit of `clk_en` is 1, every bit of `rst_hold` is 0, and `osc_stop` and `pwm_force_hi` are 0. Peripheral index map for `clk_en` and `rst_hold`:
  - 0 core
  - 1 capture timer
  - 2 PWM channel 0
  - 3 PWM channel 1
  - 4 converter
  - 5 timer A
  - 6 timer B
  - 7 timer C
  - 8 serial port 0
  - 9 serial port 1
  - 10 external interrupt logic
- R2: `reg_sel`=0 selects the control register, where bit 0 is the idle request and bit 1 is the power-down request. `reg_sel`=1 selects the option register, where bit 0 is the converter-runs-in-idle bit. A write is visible on `rd_data` and on the outputs from the cycle after the write edge. All other read bits are 0.
- R3: While idle is set and power-down is clear, core `clk_en`[0] is 0. The capture timer has `clk_en`[1]=0 and `rst_hold`[1]=1.
- R4: While idle is set and power-down is clear, both PWM channels have `clk_en`=0 and `rst_hold`=1, and `pwm_force_hi` is 2'b11.
- R5: While idle is set and power-down is clear, converter `clk_en`[4] equals the option bit.
- R6: While idle is set and power-down is clear, `clk_en`[10:5] stay 1 and `rst_hold`[10:4] stay 0.
- R7: While power-down is set, `osc_stop` is 1, every `clk_en` is 0, every `rst_hold` is 0, and `pwm_force_hi` is 0.
- R8: A control write with bit 1 set while `pd_allow` is 0 leaves power-down clear. The bit reads 0 and `osc_stop` stays 0.
- R9: A control write with both bits set while `pd_allow` is 1 sets power-down, and idle reads 0.
- R10: `irq_req` high at an edge clears idle for the next cycle, even against a same-cycle write of idle. It leaves power-down unchanged.
- R11: `ext_irq` high at an edge clears both power-down and idle for the next cycle, which restores R1's output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 option |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pd_allow | input | 1 | External permission for power-down entry |
| irq_req | input | 1 | Any enabled interrupt request |
| ext_irq | input | 1 | External interrupt request |
| clk_en | output | 11 | Per-peripheral clock enable |
| rst_hold | output | 11 | Per-peripheral reset hold |
| pwm_force_hi | output | 2 | Force PWM pins high |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
Every result of this block is due exactly one edge after its cause. Writes, interrupt wakes and power-down entry are all captured at that edge, and the outputs are decoded combinationally from the captured bits. The bench therefore drives each stimulus just after a falling edge and holds it across one rising edge. It clears the stimulus and compares the readback and all outputs at the following falling edge. Every combination of option bit, control write value and permission level is swept, and each combination is followed by a plain-interrupt wake and an external wake. A dedicated case collides a wake with a write of idle in the same cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int NPERIPH = 11;

  localparam int P_CORE = 0;
  localparam int P_CAPT = 1;
  localparam int P_PWM0 = 2;
  localparam int P_PWM1 = 3;
  localparam int P_CONV = 4;
  localparam int P_TMRA = 5;
  localparam int P_TMRB = 6;
  localparam int P_TMRC = 7;
  localparam int P_SER0 = 8;
  localparam int P_SER1 = 9;
  localparam int P_EXTI = 10;

  // How one peripheral behaves while the idle state is active
  typedef enum logic [1:0] {
    IDLE_RUN      = 2'd0,
    IDLE_HALT     = 2'd1,
    IDLE_HALT_RST = 2'd2,
    IDLE_OPTIONAL = 2'd3
  } idle_pol_e;

  typedef struct packed {
    logic idle;
    logic pdown;
    logic conv_idle_run;
  } pwr_state_t;

  function automatic idle_pol_e idle_policy(input int idx);
    idle_pol_e pol;
    case (idx)
      P_CORE:                 pol = IDLE_HALT;
      P_CAPT, P_PWM0, P_PWM1: pol = IDLE_HALT_RST;
      P_CONV:                 pol = IDLE_OPTIONAL;
      default:                pol = IDLE_RUN;
    endcase
    return pol;
  endfunction

endpackage

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs
  import pwr_mode_pkg::*;
#(
  parameter int DW       = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int OPT_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pd_allow,
  input  logic          irq_req,
  input  logic          ext_irq,
  output logic [DW-1:0] rd_data,
  output pwr_state_t    st
);

  logic idle_q, pd_q, opt_q;
  logic idle_d, pd_d, opt_d;
  logic ctrl_wr, opt_wr, pd_accept, wake_any;
  logic unused_wr_bits;

  assign ctrl_wr   = wr_en & ~reg_sel;
  assign opt_wr    = wr_en & reg_sel;
  assign pd_accept = wr_data[PD_BIT] & pd_allow;
  assign wake_any  = irq_req | ext_irq;
  assign unused_wr_bits = ^wr_data;

  always_comb begin
    pd_d = pd_q;
    if (ctrl_wr) pd_d = pd_accept;
    if (ext_irq) pd_d = 1'b0;

    idle_d = idle_q;
    if (ctrl_wr) idle_d = wr_data[IDLE_BIT] & ~pd_accept;
    if (wake_any) idle_d = 1'b0;

    opt_d = opt_wr ? wr_data[OPT_BIT] : opt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      opt_q  <= 1'b0;
    end else begin
      idle_q <= idle_d;
      pd_q   <= pd_d;
      opt_q  <= opt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (!reg_sel) begin
      rd_data[IDLE_BIT] = idle_q;
      rd_data[PD_BIT]   = pd_q;
    end else begin
      rd_data[OPT_BIT]  = opt_q;
    end
  end

  assign st.idle          = idle_q;
  assign st.pdown         = pd_q;
  assign st.conv_idle_run = opt_q;

  assert_pd_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !pd_allow) |=> !pd_q);

  assert_pd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && pd_allow && wr_data[PD_BIT] && !ext_irq) |=> (pd_q && !idle_q));

  assert_irq_clears_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !idle_q);

  assert_irq_keeps_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ext_irq && !wr_en) |=> (pd_q == $past(pd_q)));

  assert_ext_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |=> (!pd_q && !idle_q));

  assert_opt_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr |=> (opt_q == $past(wr_data[OPT_BIT])));

endmodule

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
  import pwr_mode_pkg::*;
#(
  parameter int N = NPERIPH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pwr_state_t   st,
  output logic [N-1:0] clk_en,
  output logic [N-1:0] rst_hold,
  output logic [1:0]   pwm_force_hi,
  output logic         osc_stop
);

  logic idle_act;

  assign idle_act     = st.idle & ~st.pdown;
  assign osc_stop     = st.pdown;
  assign pwm_force_hi = {2{idle_act}};

  for (genvar g = 0; g < N; g++) begin : g_periph
    always_comb begin
      clk_en[g]   = ~st.pdown;
      rst_hold[g] = 1'b0;
      if (idle_act) begin
        case (idle_policy(g))
          IDLE_HALT:     clk_en[g] = 1'b0;
          IDLE_HALT_RST: begin
            clk_en[g]   = 1'b0;
            rst_hold[g] = 1'b1;
          end
          IDLE_OPTIONAL: clk_en[g] = st.conv_idle_run;
          default:       clk_en[g] = 1'b1;
        endcase
      end
    end
  end

  assert_idle_core_capt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st.idle && !st.pdown) |-> (!clk_en[P_CORE] && !clk_en[P_CAPT] && rst_hold[P_CAPT]));

  assert_pwm_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_force_hi != 2'b00) |-> (rst_hold[P_PWM0] && rst_hold[P_PWM1]
                                 && !clk_en[P_PWM0] && !clk_en[P_PWM1]));

  assert_conv_option_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.idle && !st.pdown) |-> (clk_en[P_CONV] == st.conv_idle_run));

  assert_idle_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.idle && !st.pdown) |-> (&clk_en[N-1:P_TMRA] && (rst_hold[N-1:P_CONV] == '0)));

  assert_osc_gates_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> (clk_en == '0 && rst_hold == '0 && pwm_force_hi == 2'b00));

  assert_run_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.idle && !st.pdown) |-> (&clk_en && rst_hold == '0));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DW       = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int OPT_BIT  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic               pd_allow,
  input  logic               irq_req,
  input  logic               ext_irq,
  output logic [NPERIPH-1:0] clk_en,
  output logic [NPERIPH-1:0] rst_hold,
  output logic [1:0]         pwm_force_hi,
  output logic               osc_stop
);

  pwr_state_t st;

  pwr_ctrl_regs #(
    .DW(DW), .IDLE_BIT(IDLE_BIT), .PD_BIT(PD_BIT), .OPT_BIT(OPT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .pd_allow(pd_allow), .irq_req(irq_req),
    .ext_irq(ext_irq), .rd_data(rd_data), .st(st)
  );

  pwr_gate_map #(.N(NPERIPH)) u_gate (
    .clk(clk), .rst_n(rst_n), .st(st), .clk_en(clk_en),
    .rst_hold(rst_hold), .pwm_force_hi(pwm_force_hi), .osc_stop(osc_stop)
  );

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        pd_allow = 1'b0, irq_req = 1'b0, ext_irq = 1'b0;
  logic [10:0] clk_en, rst_hold;
  logic [1:0]  pwm_force_hi;
  logic        osc_stop;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pd_allow(pd_allow),
    .irq_req(irq_req), .ext_irq(ext_irq), .clk_en(clk_en),
    .rst_hold(rst_hold), .pwm_force_hi(pwm_force_hi), .osc_stop(osc_stop)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outputs from the mode bits, written from the requirements
  task automatic chk_outputs(input bit idle, input bit pd, input bit opt, input string req);
    logic [10:0] e_en, e_rst;
    logic [1:0]  e_pwm;
    if (pd) begin
      e_en = '0; e_rst = '0; e_pwm = 2'b00;             // R7
    end else if (idle) begin
      e_en  = 11'b111_1110_0000 | (11'(opt) << 4);      // R3 R4 R5 R6
      e_rst = 11'b000_0000_1110;
      e_pwm = 2'b11;
    end else begin
      e_en = '1; e_rst = '0; e_pwm = 2'b00;             // R1 R11
    end
    chk(clk_en == e_en, {req, " clk_en"}, 32'(clk_en), 32'(e_en));
    chk(rst_hold == e_rst, {req, " rst_hold"}, 32'(rst_hold), 32'(e_rst));
    chk(pwm_force_hi == e_pwm, {req, " pwm_force_hi"}, 32'(pwm_force_hi), 32'(e_pwm));
    chk(osc_stop == pd, {req, " osc_stop"}, 32'(osc_stop), 32'(pd));
  endtask

  task automatic do_write(input bit sel, input logic [7:0] d, input bit allow);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d; pd_allow = allow;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; pd_allow = 1'b0;
  endtask

  task automatic pulse(input bit plain, input bit ext);
    @(negedge clk);
    irq_req = plain; ext_irq = ext;
    @(negedge clk);
    irq_req = 1'b0; ext_irq = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    reg_sel = 1'b0;
    #0;
    chk(rd_data == 8'h00, "R1 ctrl reset", 32'(rd_data), 0);
    chk_outputs(0, 0, 0, "R1 reset");
    reg_sel = 1'b1;
    #1;
    chk(rd_data == 8'h00, "R1 option reset", 32'(rd_data), 0);

    for (int opt = 0; opt < 2; opt++) begin
      for (int d = 0; d < 4; d++) begin
        for (int allow = 0; allow < 2; allow++) begin
          bit e_pd, e_idle;
          string tag;
          e_pd   = d[1] && allow[0];
          e_idle = d[0] && !e_pd;
          tag = e_pd ? (d[0] ? "R9" : "R7") : (d[1] ? "R8" : (e_idle ? "R3" : "R2"));
          do_reset();
          do_write(1'b1, 8'(opt), 1'b0);
          reg_sel = 1'b1;
          #1;
          chk(rd_data == 8'(opt), "R2 option readback", 32'(rd_data), 32'(opt));
          do_write(1'b0, 8'(d), allow[0]);
          reg_sel = 1'b0;
          #1;
          chk(rd_data == {6'b0, e_pd, e_idle}, {tag, " ctrl readback"},
              32'(rd_data), 32'({e_pd, e_idle}));
          chk_outputs(e_idle, e_pd, opt[0], tag);
          pulse(1'b1, 1'b0);
          #1;
          chk(rd_data == {6'b0, e_pd, 1'b0}, "R10 plain wake", 32'(rd_data), 32'({e_pd, 1'b0}));
          chk_outputs(0, e_pd, opt[0], "R10 after wake");
          pulse(1'b0, 1'b1);
          #1;
          chk(rd_data == 8'h00, "R11 ext wake", 32'(rd_data), 0);
          chk_outputs(0, 0, opt[0], "R11 after ext wake");
        end
      end
    end

    // R10: a wake in the same cycle as a write of idle wins
    do_reset();
    @(negedge clk);
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'h01; irq_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; irq_req = 1'b0;
    #1;
    chk(rd_data == 8'h00, "R10 collision", 32'(rd_data), 0);
    chk_outputs(0, 0, 0, "R10 collision");

    // R5: the option bit alone, written while idle, changes only the converter
    do_write(1'b0, 8'h01, 1'b0);
    do_write(1'b1, 8'h01, 1'b0);
    #1;
    chk_outputs(1, 0, 1, "R5 option during idle");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule